// File: doc/BRIEF.md
# Switchable ROM/RAM Bank Mapper

This block sits between a CPU and a cartridge's ROM and external RAM arrays. It decodes CPU writes in the lower half of the address space (0x0000-0x7FFF) into control state: a RAM access enable, a 5-bit low ROM bank field, a 2-bit secondary field and a banking mode bit. From that state it forms the bank number for the switchable 16 KiB ROM window, the 8 KiB external RAM bank, and the physical ROM and RAM addresses of the current CPU cycle.

The 2-bit secondary field has two uses, chosen by the mode bit. In mode 0 it supplies ROM bank bits [6:5]. In mode 1 it selects the RAM bank. When the mode changes, the copy that no longer applies is cleared. A size input gives the ROM bank count as a power of two, and the bank number is masked down to that count. RAM reads and writes pass through only while access is enabled. Otherwise reads return 0xFF and writes are dropped.

Top module: `bank_mapper`

## Requirements
- R1: After reset the ROM bank output is 1, the RAM bank is 0, the mode is 0, RAM access is off, and RAM-window read data is 0xFF.
- R2: A write is decoded only when `cpu_addr[15]` is 0. Bits [14:13] then pick the target: 0 is the enable, 1 is the low ROM bank, 2 is the secondary field, 3 is the mode. Writes with `cpu_addr[15]` = 1 leave all control state unchanged.
- R3: Writing 0x0A to target 0 turns RAM access on. Writing 0x00 turns it off. Any other value leaves it as it was.
- R4: Target 1 loads data bits [4:0] into ROM bank bits [4:0]. A zero is stored as 1. Bank bits [6:5] are kept.
- R5: Target 2 takes data bits [1:0]. In mode 0 they become ROM bank bits [6:5]. In mode 1 they become the RAM bank and the ROM bank is unchanged.
- R6: Target 3 loads data bit 0 into the mode. Writing mode 1 clears ROM bank bits [6:5]. Writing mode 0 sets the RAM bank to 0.
- R7: The ROM bank output equals the stored bank ANDed with (2^`rom_size_log2` − 1). The mask acts combinationally and the stored bank is kept, so a larger size restores the upper bits.
- R8: `rom_addr` is {0, `cpu_addr[13:0]`} when `cpu_addr[15:14]` is 0. Otherwise it is {ROM bank, `cpu_addr[13:0]`}.
- R9: `ram_addr` is {RAM bank, `cpu_addr[12:0]`}. `ram_wr` is high only when `cpu_wr` is high, the address is in 0xA000-0xBFFF and access is on. `cpu_rdata_ram` is `ram_rdata` while access is on and 0xFF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_wdata | input | 8 | CPU write data |
| rom_size_log2 | input | 3 | log2 of the ROM bank count |
| ram_rdata | input | 8 | Data read from the external RAM array |
| rom_bank | output | 7 | Effective switchable ROM bank |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_access | output | 1 | RAM access enabled |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 15 | Physical RAM address |
| ram_wr | output | 1 | Gated RAM write strobe |
| cpu_rdata_ram | output | 8 | RAM-window read data returned to the CPU |

## Verification
Every control register drives a port on the clock edge of the write that changes it. A bad decode, a missed zero promotion or a stale secondary copy therefore shows up as a wrong `rom_bank` or `ram_bank` when the ports are sampled at the next falling edge. A bad enable shows up in the same cycle on `ram_wr` and `cpu_rdata_ram`. The mode bit has no port of its own, so a wrong mode appears only at the next secondary-field write, which lands in the wrong bank field. The directed tests make that write straight after each mode change. Mask faults are combinational and appear as soon as `rom_size_log2` changes.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_LOW    = 2'd1,
      SEL_SECOND = 2'd2,
      SEL_MODE   = 2'd3
   } reg_sel_t;

   localparam logic [7:0] KEY_ON  = 8'h0A;
   localparam logic [7:0] KEY_OFF = 8'h00;
   localparam logic [7:0] OPEN_BUS = 8'hFF;
endpackage

// File: rtl/bm_ctrl_regs.sv
module bm_ctrl_regs
   import bank_mapper_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LOW_W  = 5,
   parameter int SEC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_t          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [LOW_W-1:0]  low_q,
   output logic [SEC_W-1:0]  rom_hi_q,
   output logic [SEC_W-1:0]  ram_q,
   output logic              mode_q,
   output logic              access_q
);
   logic [LOW_W-1:0] low_in;

   generate
      if (LOW_W > DATA_W) begin : g_bad_low
         $error("LOW_W must not exceed DATA_W");
      end
      if (SEC_W > DATA_W) begin : g_bad_sec
         $error("SEC_W must not exceed DATA_W");
      end
   endgenerate

   // zero is promoted to one
   always_comb begin
      low_in = wdata[LOW_W-1:0];
      if (low_in == '0) low_in = LOW_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q    <= LOW_W'(1);
         rom_hi_q <= '0;
         ram_q    <= '0;
         mode_q   <= 1'b0;
         access_q <= 1'b0;
      end else if (wr_stb) begin
         case (sel)
            SEL_ENABLE: begin
               if (wdata == KEY_ON)       access_q <= 1'b1;
               else if (wdata == KEY_OFF) access_q <= 1'b0;
            end
            SEL_LOW: low_q <= low_in;
            SEL_SECOND: begin
               if (mode_q) ram_q    <= wdata[SEC_W-1:0];
               else        rom_hi_q <= wdata[SEC_W-1:0];
            end
            SEL_MODE: begin
               mode_q <= wdata[0];
               if (wdata[0]) rom_hi_q <= '0;
               else          ram_q    <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bm_bank_limit.sv
module bm_bank_limit #(
   parameter int BANK_W = 7,
   parameter int SIZE_W = 3
) (
   input  logic [BANK_W-1:0] raw_bank,
   input  logic [SIZE_W-1:0] size_log2,
   output logic [BANK_W-1:0] eff_bank
);
   generate
      if ((1 << SIZE_W) < BANK_W) begin : g_bad_size
         $error("SIZE_W too narrow for BANK_W");
      end
      for (genvar i = 0; i < BANK_W; i++) begin : g_bit
         assign eff_bank[i] = raw_bank[i] & (32'(size_log2) > i);
      end
   endgenerate
endmodule

// File: rtl/bm_addr_map.sv
module bm_addr_map #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int BANK_W  = 7,
   parameter int SEC_W   = 2,
   parameter int WIN_W   = 14,
   parameter int RWIN_W  = 13,
   parameter logic [DATA_W-1:0] IDLE_DATA = '1
) (
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic                     cpu_wr,
   input  logic [BANK_W-1:0]        bank,
   input  logic [SEC_W-1:0]         ram_bank,
   input  logic                     access,
   input  logic [DATA_W-1:0]        ram_rdata,
   output logic [BANK_W+WIN_W-1:0]  rom_addr,
   output logic [SEC_W+RWIN_W-1:0]  ram_addr,
   output logic                     ram_wr,
   output logic [DATA_W-1:0]        rdata
);
   localparam int WSEL_W = ADDR_W - WIN_W;
   localparam int RSEL_W = ADDR_W - RWIN_W;
   localparam logic [RSEL_W-1:0] RAM_REGION = RSEL_W'(5);

   logic fixed_win, ram_win;

   generate
      if (WIN_W >= ADDR_W || RWIN_W >= ADDR_W) begin : g_bad_win
         $error("window widths must be below ADDR_W");
      end
   endgenerate

   assign fixed_win = (cpu_addr[ADDR_W-1 -: WSEL_W] == '0);
   assign ram_win   = (cpu_addr[ADDR_W-1 -: RSEL_W] == RAM_REGION);
   assign rom_addr  = {fixed_win ? {BANK_W{1'b0}} : bank, cpu_addr[WIN_W-1:0]};
   assign ram_addr  = {ram_bank, cpu_addr[RWIN_W-1:0]};
   assign ram_wr    = cpu_wr & ram_win & access;
   assign rdata     = access ? ram_rdata : IDLE_DATA;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bank_mapper_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int LOW_W  = 5,
   parameter int SEC_W  = 2,
   parameter int WIN_W  = 14,
   parameter int RWIN_W = 13,
   localparam int BANK_W = LOW_W + SEC_W,
   localparam int SIZE_W = $clog2(BANK_W + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic                    cpu_wr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   input  logic [SIZE_W-1:0]       rom_size_log2,
   input  logic [DATA_W-1:0]       ram_rdata,
   output logic [BANK_W-1:0]       rom_bank,
   output logic [SEC_W-1:0]        ram_bank,
   output logic                    ram_access,
   output logic [BANK_W+WIN_W-1:0] rom_addr,
   output logic [SEC_W+RWIN_W-1:0] ram_addr,
   output logic                    ram_wr,
   output logic [DATA_W-1:0]       cpu_rdata_ram
);
   logic [LOW_W-1:0] low_q;
   logic [SEC_W-1:0] rom_hi_q;
   logic             mode_q;
   logic             ctrl_stb;

   assign ctrl_stb = cpu_wr & ~cpu_addr[ADDR_W-1];

   bm_ctrl_regs #(.DATA_W(DATA_W), .LOW_W(LOW_W), .SEC_W(SEC_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (ctrl_stb),
      .sel      (reg_sel_t'(cpu_addr[ADDR_W-2 -: 2])),
      .wdata    (cpu_wdata),
      .low_q    (low_q),
      .rom_hi_q (rom_hi_q),
      .ram_q    (ram_bank),
      .mode_q   (mode_q),
      .access_q (ram_access)
   );

   bm_bank_limit #(.BANK_W(BANK_W), .SIZE_W(SIZE_W)) u_limit (
      .raw_bank  ({rom_hi_q, low_q}),
      .size_log2 (rom_size_log2),
      .eff_bank  (rom_bank)
   );

   bm_addr_map #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .SEC_W(SEC_W),
      .WIN_W(WIN_W), .RWIN_W(RWIN_W), .IDLE_DATA(OPEN_BUS)
   ) u_map (
      .cpu_addr  (cpu_addr),
      .cpu_wr    (cpu_wr),
      .bank      (rom_bank),
      .ram_bank  (ram_bank),
      .access    (ram_access),
      .ram_rdata (ram_rdata),
      .rom_addr  (rom_addr),
      .ram_addr  (ram_addr),
      .ram_wr    (ram_wr),
      .rdata     (cpu_rdata_ram)
   );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic        cpu_wr,
   input logic [7:0]  cpu_wdata,
   input logic [2:0]  rom_size_log2,
   input logic [6:0]  rom_bank,
   input logic [1:0]  ram_bank,
   input logic        ram_access,
   input logic [20:0] rom_addr,
   input logic        ram_wr
);
   // R3
   p_enable_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h0A) |=> ram_access);
   p_enable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h00) |=> !ram_access);
   p_enable_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'd0 && cpu_wdata != 8'h0A && cpu_wdata != 8'h00)
      |=> $stable(ram_access));
   // R2
   p_upper_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_wr || cpu_addr[15]) |=> ($stable(ram_access) && $stable(ram_bank)));
   // R4
   p_low_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_size_log2 >= 3'd5) |-> (rom_bank[4:0] != 5'd0));
   // R6
   p_mode1_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'd3 && cpu_wdata[0]) |=> (rom_bank[6:5] == 2'd0));
   p_mode0_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr[15:13] == 3'd3 && !cpu_wdata[0]) |=> (ram_bank == 2'd0));
   // R7
   p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_size_log2 < 3'd7) |-> ((rom_bank >> rom_size_log2) == 7'd0));
   // R8
   p_fixed_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == 7'd0));
   // R9
   p_ram_wr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_wr |-> (ram_access && cpu_wr && cpu_addr[15:13] == 3'b101));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_addr      (cpu_addr),
   .cpu_wr        (cpu_wr),
   .cpu_wdata     (cpu_wdata),
   .rom_size_log2 (rom_size_log2),
   .rom_bank      (rom_bank),
   .ram_bank      (ram_bank),
   .ram_access    (ram_access),
   .rom_addr      (rom_addr),
   .ram_wr        (ram_wr)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [2:0]  rom_size_log2 = 3'd7;
   logic [7:0]  ram_rdata = 8'h5A;
   logic [6:0]  rom_bank;
   logic [1:0]  ram_bank;
   logic        ram_access;
   logic [20:0] rom_addr;
   logic [14:0] ram_addr;
   logic        ram_wr;
   logic [7:0]  cpu_rdata_ram;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bank_mapper uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .rom_size_log2(rom_size_log2), .ram_rdata(ram_rdata),
      .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_access(ram_access),
      .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_wr(ram_wr),
      .cpu_rdata_ram(cpu_rdata_ram)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 rom_bank", 32'(rom_bank), 1);
      check("R1 ram_bank", 32'(ram_bank), 0);
      check("R1 access", 32'(ram_access), 0);
      check("R1 rdata", 32'(cpu_rdata_ram), 32'hFF);
      wr(16'h4000, 8'h02);
      check("R1 mode0 after reset", 32'(rom_bank), 32'h41);
      wr(16'h4000, 8'h00);
   endtask

   task automatic t_enable;
      wr(16'h0000, 8'h0A); check("R3 enable", 32'(ram_access), 1);
      wr(16'h1FFF, 8'h55); check("R3 other keeps on", 32'(ram_access), 1);
      wr(16'h0100, 8'h00); check("R3 disable", 32'(ram_access), 0);
      wr(16'h1000, 8'h3A); check("R3 other keeps off", 32'(ram_access), 0);
   endtask

   task automatic t_low;
      wr(16'h2000, 8'h00); check("R4 zero promoted", 32'(rom_bank), 1);
      wr(16'h2100, 8'hF3); check("R4 low field", 32'(rom_bank), 32'h13);
   endtask

   task automatic t_second_mode0;
      wr(16'h4000, 8'h02); check("R5 mode0 upper", 32'(rom_bank), 32'h53);
      check("R5 mode0 ram untouched", 32'(ram_bank), 0);
      wr(16'h3FFF, 8'h05); check("R4 keeps upper", 32'(rom_bank), 32'h45);
   endtask

   task automatic t_mode_switch;
      wr(16'h6000, 8'h01); check("R6 mode1 clears upper", 32'(rom_bank), 32'h05);
      wr(16'h5000, 8'hFF); check("R5 mode1 ram bank", 32'(ram_bank), 3);
      check("R5 mode1 rom unchanged", 32'(rom_bank), 32'h05);
      wr(16'h7FFF, 8'hFE); check("R6 mode0 clears ram", 32'(ram_bank), 0);
      check("R6 mode0 rom kept", 32'(rom_bank), 32'h05);
      wr(16'h4000, 8'h01); check("R5 mode0 again upper", 32'(rom_bank), 32'h25);
   endtask

   task automatic t_mask;
      rom_size_log2 = 3'd4; #1; check("R7 mask 16", 32'(rom_bank), 32'h05);
      rom_size_log2 = 3'd0; #1; check("R7 mask 1", 32'(rom_bank), 0);
      rom_size_log2 = 3'd7; #1; check("R7 restore", 32'(rom_bank), 32'h25);
      rom_size_log2 = 3'd5;
      wr(16'h2000, 8'h00); check("R7 zero then mask", 32'(rom_bank), 32'h01);
      rom_size_log2 = 3'd7; #1; check("R7 raw kept", 32'(rom_bank), 32'h21);
      wr(16'h2000, 8'h05);
   endtask

   task automatic t_addr;
      @(negedge clk);
      cpu_addr = 16'h1234; #1; check("R8 fixed window", 32'(rom_addr), 32'h01234);
      cpu_addr = 16'h5678; #1;
      check("R8 switched window", 32'(rom_addr), (32'h25 << 14) | 32'h1678);
   endtask

   task automatic t_ram;
      @(negedge clk);
      cpu_addr = 16'hA123; cpu_wr = 1'b1; #1;
      check("R9 wr blocked", 32'(ram_wr), 0);
      check("R9 rdata idle", 32'(cpu_rdata_ram), 32'hFF);
      cpu_wr = 1'b0;
      wr(16'h0000, 8'h0A);
      wr(16'h6000, 8'h01);
      wr(16'h4000, 8'h02);
      @(negedge clk);
      cpu_addr = 16'hA123; cpu_wr = 1'b1; #1;
      check("R9 wr pass", 32'(ram_wr), 1);
      check("R9 ram addr", 32'(ram_addr), 32'h4123);
      check("R9 rdata pass", 32'(cpu_rdata_ram), 32'h5A);
      cpu_addr = 16'hC123; #1;
      check("R9 wr outside window", 32'(ram_wr), 0);
      cpu_wr = 1'b0;
   endtask

   task automatic t_ignored;
      wr(16'hC000, 8'h00); check("R2 upper write keeps access", 32'(ram_access), 1);
      wr(16'hE000, 8'h01); check("R2 upper write keeps ram bank", 32'(ram_bank), 2);
      check("R2 upper write keeps rom bank", 32'(rom_bank), 32'h05);
      wr(16'h8000, 8'h00); check("R2 keeps rom bank", 32'(rom_bank), 32'h05);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_low();
      t_second_mode0();
      t_mode_switch();
      t_mask();
      t_addr();
      t_ram();
      t_ignored();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule